// File: doc/BRIEF.md
# Parallel Programming Port Target

This block is the device side of a parallel programming port. A host drives five mode-select lines, an address, a data byte, an active-low program strobe and a flag that says the programming voltage is present. The block decodes the mode lines into an operation and holds a small byte-wide code array. On a strobe it runs a self-timed byte write, a whole-array erase or the setting of one of three lock bits. While that runs it holds its ready line low.

Outside a timed operation, the data port returns whatever the mode lines ask for. That is the addressed code byte, the lock state or one of three fixed signature bytes. Lock bits restrict later access. Lock 1 blocks code writes. Lock 2 also masks code reads. Lock 3 is stored and reported only. The programming-voltage check is a plain digital input.

Top module: `pgm_port_target`

## Requirements
- R1: The mode lines `mode[4:0]` select the operation: 01111 write code, 00011 read code, 10100 erase, 11111 lock 1, 11100 lock 2, 10110 lock 3, 11010 read locks, 00000 signature. In read-code mode `dout` shows the byte at `addr` one clock after mode and address are sampled.
- R2: A write, erase or lock operation starts only on a clock edge where `prog_n` is sampled low after being sampled high on the previous edge, and only when `hv_ok` is high on that edge. Otherwise the strobe has no effect.
- R3: A started byte write or lock-bit set holds `rdy` low for exactly `WRITE_CYCLES` clocks, starting the clock after the starting edge.
- R4: A started erase holds `rdy` low for exactly `ERASE_CYCLES` clocks.
- R5: A byte write stores the old byte AND the supplied data. Bits can only go from 1 to 0.
- R6: Erase sets every byte of the array to 0xFF and clears all three lock bits.
- R7: In signature mode, address 0x000 reads 0x1E, 0x100 reads 0x52, 0x200 reads 0x06, and any other address reads 0x00.
- R8: In read-locks mode, lock bits 1, 2 and 3 appear on `dout[2]`, `dout[3]` and `dout[4]`. All other data bits are 0.
- R9: While lock 1 is set, a write-code strobe is ignored: `rdy` stays high and the byte is unchanged.
- R10: While lock 2 is set, read-code mode returns 0xFF.
- R11: Strobes that arrive while `rdy` is low are ignored.
- R12: After reset, `rdy` is high, `dout` is 0xFF and all lock bits are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Mode-select lines, encoding as in R1 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| prog_n | input | 1 | Active-low program strobe |
| hv_ok | input | 1 | Programming voltage present |
| dout | output | 8 | Read data, lock state or signature byte |
| rdy | output | 1 | High when idle, low while a timed operation runs |

## Verification
Read results in every mode come out one clock after mode and address are sampled. The bench therefore sets inputs on a falling edge and reads `dout` on the next falling edge. A strobe driven low on a falling edge starts the operation at the following rising edge, so `rdy` is first seen low half a clock later. The bench counts falling edges while `rdy` stays low and compares that count with `WRITE_CYCLES` or `ERASE_CYCLES` exactly. Effects of a write, erase or lock are checked only after `rdy` is high again, through the ordinary read and read-locks modes.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_WRITE,
      OP_READ,
      OP_ERASE,
      OP_LOCK1,
      OP_LOCK2,
      OP_LOCK3,
      OP_RDLOCK,
      OP_SIG
   } op_e;

   localparam int MODE_W = 5;
   localparam int NUM_LOCKS = 3;

   localparam logic [MODE_W-1:0] MS_WRITE  = 5'b01111;
   localparam logic [MODE_W-1:0] MS_READ   = 5'b00011;
   localparam logic [MODE_W-1:0] MS_ERASE  = 5'b10100;
   localparam logic [MODE_W-1:0] MS_LOCK1  = 5'b11111;
   localparam logic [MODE_W-1:0] MS_LOCK2  = 5'b11100;
   localparam logic [MODE_W-1:0] MS_LOCK3  = 5'b10110;
   localparam logic [MODE_W-1:0] MS_RDLOCK = 5'b11010;
   localparam logic [MODE_W-1:0] MS_SIG    = 5'b00000;

   localparam logic [7:0] BYTE_ERASED = 8'hFF;
   localparam logic [7:0] SIG_MAKER   = 8'h1E;
   localparam logic [7:0] SIG_FAMILY  = 8'h52;
   localparam logic [7:0] SIG_VARIANT = 8'h06;

endpackage

// File: rtl/pgm_mode_decode.sv
module pgm_mode_decode
   import pgm_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   output op_e               op
);

   always_comb begin
      unique case (mode)
         MS_WRITE:  op = OP_WRITE;
         MS_READ:   op = OP_READ;
         MS_ERASE:  op = OP_ERASE;
         MS_LOCK1:  op = OP_LOCK1;
         MS_LOCK2:  op = OP_LOCK2;
         MS_LOCK3:  op = OP_LOCK3;
         MS_RDLOCK: op = OP_RDLOCK;
         MS_SIG:    op = OP_SIG;
         default:   op = OP_NONE;
      endcase
   end

endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
   import pgm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int WRITE_CYCLES = 8,
   parameter int ERASE_CYCLES = 2100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  op_e                  op,
   input  logic                 prog_n,
   input  logic                 hv_ok,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [7:0]           din,
   input  logic [NUM_LOCKS-1:0] lock,
   output logic                 busy,
   output logic                 wr_en,
   output logic                 wr_and,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [7:0]           wr_data,
   output logic [NUM_LOCKS-1:0] lock_set,
   output logic                 lock_clr
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
   localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYCLES - 1);
   localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_CYCLES - 1);
   localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(DEPTH);

   logic              prog_d;
   logic              busy_q;
   op_e               act_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic              accept;
   logic              start;
   logic              done;

   always_comb begin
      case (op)
         OP_WRITE:                    accept = ~lock[0];
         OP_ERASE, OP_LOCK1,
         OP_LOCK2, OP_LOCK3:          accept = 1'b1;
         default:                     accept = 1'b0;
      endcase
   end

   assign start = prog_d & ~prog_n & hv_ok & ~busy_q & accept;
   assign done  = busy_q & (cnt_q == ((act_q == OP_ERASE) ? ER_LAST : WR_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_d <= 1'b0;
         busy_q <= 1'b0;
         act_q  <= OP_NONE;
         cnt_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         prog_d <= prog_n;
         if (start) begin
            busy_q <= 1'b1;
            act_q  <= op;
            cnt_q  <= '0;
            addr_q <= addr;
            data_q <= din;
         end else if (busy_q) begin
            if (done) begin
               busy_q <= 1'b0;
               act_q  <= OP_NONE;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      wr_en    = 1'b0;
      wr_and   = 1'b1;
      wr_addr  = addr_q;
      wr_data  = data_q;
      lock_set = '0;
      lock_clr = 1'b0;
      if (busy_q) begin
         case (act_q)
            OP_WRITE: wr_en = done;
            OP_ERASE: begin
               wr_en    = (cnt_q < SWEEP_END);
               wr_and   = 1'b0;
               wr_addr  = cnt_q[ADDR_W-1:0];
               wr_data  = BYTE_ERASED;
               lock_clr = done;
            end
            OP_LOCK1: lock_set[0] = done;
            OP_LOCK2: lock_set[1] = done;
            OP_LOCK3: lock_set[2] = done;
            default: ;
         endcase
      end
   end

   assign busy = busy_q;

endmodule

// File: rtl/pgm_code_array.sv
module pgm_code_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_and,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (wr_and) mem[wr_addr] <= mem[wr_addr] & wr_data;
         else        mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pgm_lock_bank.sv
module pgm_lock_bank
   import pgm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOCKS-1:0] set,
   input  logic                 clr,
   output logic [NUM_LOCKS-1:0] lock
);

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= 1'b0;
         else if (clr)    q <= 1'b0;
         else if (set[i]) q <= 1'b1;
      end
      assign lock[i] = q;
   end

endmodule

// File: rtl/pgm_port_target.sv
module pgm_port_target
   import pgm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int WRITE_CYCLES = 8,
   parameter int ERASE_CYCLES = 2100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   input  logic              prog_n,
   input  logic              hv_ok,
   output logic [7:0]        dout,
   output logic              rdy
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] SIG_A0 = '0;
   localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(12'h100);
   localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(12'h200);

   if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr_w
      $error("pgm_port_target: ADDR_W must lie in 10..16");
   end
   if (WRITE_CYCLES < 1) begin : g_bad_write
      $error("pgm_port_target: WRITE_CYCLES must be at least 1");
   end
   if (ERASE_CYCLES < DEPTH || ERASE_CYCLES <= WRITE_CYCLES) begin : g_bad_erase
      $error("pgm_port_target: ERASE_CYCLES must cover the array and exceed WRITE_CYCLES");
   end

   op_e                  op;
   logic                 busy;
   logic                 wr_en;
   logic                 wr_and;
   logic [ADDR_W-1:0]    wr_addr;
   logic [7:0]           wr_data;
   logic [NUM_LOCKS-1:0] lock_set;
   logic                 lock_clr;
   logic [NUM_LOCKS-1:0] lock_q;
   logic [7:0]           arr_rd;
   logic [7:0]           rd_next;
   logic [7:0]           dout_q;

   pgm_mode_decode u_dec (
      .mode (mode),
      .op   (op)
   );

   pgm_seq #(
      .ADDR_W       (ADDR_W),
      .WRITE_CYCLES (WRITE_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .prog_n   (prog_n),
      .hv_ok    (hv_ok),
      .addr     (addr),
      .din      (din),
      .lock     (lock_q),
      .busy     (busy),
      .wr_en    (wr_en),
      .wr_and   (wr_and),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .lock_set (lock_set),
      .lock_clr (lock_clr)
   );

   pgm_code_array #(
      .ADDR_W (ADDR_W)
   ) u_arr (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_and  (wr_and),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_data (arr_rd)
   );

   pgm_lock_bank u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (lock_set),
      .clr   (lock_clr),
      .lock  (lock_q)
   );

   always_comb begin
      case (op)
         OP_READ:   rd_next = lock_q[1] ? BYTE_ERASED : arr_rd;
         OP_RDLOCK: rd_next = {3'b000, lock_q, 2'b00};
         OP_SIG: begin
            if      (addr == SIG_A0) rd_next = SIG_MAKER;
            else if (addr == SIG_A1) rd_next = SIG_FAMILY;
            else if (addr == SIG_A2) rd_next = SIG_VARIANT;
            else                     rd_next = 8'h00;
         end
         default:   rd_next = BYTE_ERASED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= BYTE_ERASED;
      else        dout_q <= rd_next;
   end

   assign dout = dout_q;
   assign rdy  = ~busy;

endmodule

// File: rtl/pgm_port_target_chk.sv
module pgm_port_target_chk
   import pgm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int WRITE_CYCLES = 8,
   parameter int ERASE_CYCLES = 2100
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        mode,
   input logic [ADDR_W-1:0] addr,
   input logic              prog_n,
   input logic              hv_ok,
   input logic [7:0]        dout,
   input logic              rdy,
   input logic [2:0]        lock
);

   int unsigned low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   low_len <= 0;
      else if (rdy) low_len <= 0;
      else          low_len <= low_len + 1;
   end

   p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy) |-> ($past(hv_ok) && !$past(prog_n) && $past(prog_n, 2)));

   p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> (low_len == WRITE_CYCLES || low_len == ERASE_CYCLES));

   p_erase_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rdy) && low_len == ERASE_CYCLES) |-> (lock == 3'b000));

   p_sig_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MS_SIG && addr == '0) |=> (dout == SIG_MAKER));

   p_rdlock_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MS_RDLOCK) |=> (dout[7:5] == 3'b000 && dout[1:0] == 2'b00));

   p_write_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rdy) && $past(mode) == MS_WRITE) |-> !$past(lock[0]));

   p_read_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && lock[1] && mode == MS_READ) |=> (dout == BYTE_ERASED));

endmodule

bind pgm_port_target pgm_port_target_chk #(
   .ADDR_W       (ADDR_W),
   .WRITE_CYCLES (WRITE_CYCLES),
   .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mode   (mode),
   .addr   (addr),
   .prog_n (prog_n),
   .hv_ok  (hv_ok),
   .dout   (dout),
   .rdy    (rdy),
   .lock   (lock_q)
);

// File: tb/pgm_port_target_tb.sv
`timescale 1ns/1ps
module pgm_port_target_tb;
   import pgm_pkg::*;

   localparam int ADDR_W = 11;
   localparam int WR_CYC = 8;
   localparam int ER_CYC = 2100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        mode = MS_RDLOCK;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        din = 8'h00;
   logic              prog_n = 1'b1;
   logic              hv_ok = 1'b1;
   logic [7:0]        dout;
   logic              rdy;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   pgm_port_target #(
      .ADDR_W       (ADDR_W),
      .WRITE_CYCLES (WR_CYC),
      .ERASE_CYCLES (ER_CYC)
   ) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .addr   (addr),
      .din    (din),
      .prog_n (prog_n),
      .hv_ok  (hv_ok),
      .dout   (dout),
      .rdy    (rdy)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Strobe one operation and return the number of clocks rdy stays low.
   task automatic strobe(logic [4:0] m, int a, logic [7:0] d, logic hv, output int len);
      @(negedge clk);
      mode = m; addr = ADDR_W'(a); din = d; hv_ok = hv;
      @(negedge clk);
      prog_n = 1'b0;
      @(negedge clk);
      prog_n = 1'b1;
      len = 0;
      while (rdy == 1'b0 && len < 5000) begin
         len++;
         @(negedge clk);
      end
      hv_ok = 1'b1;
   endtask

   task automatic rd(logic [4:0] m, int a, output int v);
      @(negedge clk);
      mode = m; addr = ADDR_W'(a);
      @(negedge clk);
      v = dout;
   endtask

   task automatic t_reset;
      int v;
      check("R12 rdy after reset", rdy, 1);
      check("R12 dout after reset", dout, 8'hFF);
      rd(MS_RDLOCK, 0, v);
      check("R12 locks clear", v, 8'h00);
   endtask

   task automatic t_erase;
      int len, v;
      strobe(MS_ERASE, 0, 8'h00, 1'b1, len);
      check("R4 erase busy length", len, ER_CYC);
      rd(MS_READ, 0, v);           check("R6 erased byte first", v, 8'hFF);
      rd(MS_READ, 12'h5A5, v);     check("R6 erased byte middle", v, 8'hFF);
      rd(MS_READ, 12'h7FF, v);     check("R6 erased byte last", v, 8'hFF);
   endtask

   task automatic t_write_and;
      int len, v;
      strobe(MS_WRITE, 12'h123, 8'hA5, 1'b1, len);
      check("R3 write busy length", len, WR_CYC);
      rd(MS_READ, 12'h123, v);     check("R1 read after write", v, 8'hA5);
      strobe(MS_WRITE, 12'h123, 8'h3C, 1'b1, len);
      rd(MS_READ, 12'h123, v);     check("R5 second write ANDs", v, 8'h24);
      rd(MS_READ, 12'h124, v);     check("R1 neighbour untouched", v, 8'hFF);
   endtask

   task automatic t_hv_gate;
      int len, v;
      strobe(MS_WRITE, 12'h050, 8'h00, 1'b0, len);
      check("R2 no busy without hv", len, 0);
      rd(MS_READ, 12'h050, v);     check("R2 byte kept without hv", v, 8'hFF);
   endtask

   task automatic t_busy_ignore;
      int len, v;
      @(negedge clk);
      mode = MS_WRITE; addr = ADDR_W'(12'h200); din = 8'h11;
      @(negedge clk);
      prog_n = 1'b0;
      @(negedge clk);
      prog_n = 1'b1;
      addr = ADDR_W'(12'h201); din = 8'h00;
      @(negedge clk);
      prog_n = 1'b0;
      @(negedge clk);
      prog_n = 1'b1;
      len = 2;
      while (rdy == 1'b0 && len < 5000) begin
         len++;
         @(negedge clk);
      end
      check("R11 busy not extended", len, WR_CYC);
      rd(MS_READ, 12'h200, v);     check("R11 first write done", v, 8'h11);
      rd(MS_READ, 12'h201, v);     check("R11 busy strobe ignored", v, 8'hFF);
   endtask

   task automatic t_signature;
      int v;
      rd(MS_SIG, 12'h000, v);      check("R7 sig 0x000", v, 8'h1E);
      rd(MS_SIG, 12'h100, v);      check("R7 sig 0x100", v, 8'h52);
      rd(MS_SIG, 12'h200, v);      check("R7 sig 0x200", v, 8'h06);
      rd(MS_SIG, 12'h300, v);      check("R7 sig other", v, 8'h00);
   endtask

   task automatic t_locks;
      int len, v;
      strobe(MS_LOCK1, 0, 8'h00, 1'b1, len);
      check("R3 lock busy length", len, WR_CYC);
      rd(MS_RDLOCK, 0, v);         check("R8 lock1 on bit2", v, 8'h04);
      strobe(MS_WRITE, 12'h060, 8'h00, 1'b1, len);
      check("R9 locked write no busy", len, 0);
      rd(MS_READ, 12'h060, v);     check("R9 locked write ignored", v, 8'hFF);
      rd(MS_READ, 12'h123, v);     check("R10 readable before lock2", v, 8'h24);
      strobe(MS_LOCK2, 0, 8'h00, 1'b1, len);
      rd(MS_RDLOCK, 0, v);         check("R8 lock2 on bit3", v, 8'h0C);
      rd(MS_READ, 12'h123, v);     check("R10 read masked", v, 8'hFF);
      strobe(MS_LOCK3, 0, 8'h00, 1'b1, len);
      rd(MS_RDLOCK, 0, v);         check("R8 lock3 on bit4", v, 8'h1C);
      strobe(MS_ERASE, 0, 8'h00, 1'b1, len);
      check("R4 erase busy length again", len, ER_CYC);
      rd(MS_RDLOCK, 0, v);         check("R6 erase clears locks", v, 8'h00);
      rd(MS_READ, 12'h200, v);     check("R6 erase clears data", v, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_erase();
      t_write_and();
      t_hv_gate();
      t_busy_ignore();
      t_signature();
      t_locks();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule